// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the two error counters of a CAN node and derives the node's fault-confinement state from them. A protocol engine drives it with single-cycle strobes:

- a transmit error or a receive error, together with an error type code;
- a frame sent without error, or a frame received without error.

From these the block keeps a transmit error counter and a receive error counter. It reports a warning level, the error-passive state and the bus-off state.

It also decides how the engine signals an error. The error flag is dominant while the node is error-active and recessive once it is error-passive or bus-off. The flag length is always six bits.

The block raises a one-cycle suspend request after a transmission completes while the node is error-passive. In bus-off it withdraws both the transmit and receive enables. A last-error-code register keeps the type of the most recent error.

The counters have unequal roles. Only the transmit counter can take the node off the bus. The receive counter can at most make the node error-passive. Bus-off ends only with a reset.

Top module: `can_fault_conf`

## Requirements
- R1: An error strobe adds 8 to its own counter: tx_err_i to tec_o, rx_err_i to rec_o. The new value is visible one cycle after the strobe.
- R2: A success strobe subtracts 1 from its own counter: tx_ok_i from tec_o, rx_ok_i from rec_o. A counter at 0 stays at 0.
- R3: If an error strobe and a success strobe for the same counter arrive in the same cycle, only the +8 is applied.
- R4: warn_o is 1 while either counter is 96 or more, and 0 once both counters are below 96.
- R5: passive_o is 1 when either counter exceeds 127 and the node is not bus-off. flag_recessive_o is 1 when the node is error-passive or bus-off, and 0 when it is error-active. flag_len_o is always 6.
- R6: busoff_o rises only when a transmit error takes tec_o above 255. rec_o saturates at 511 and never causes bus-off.
- R7: Bus-off is sticky. While busoff_o is 1, all strobes are ignored, tec_o, rec_o and lec_o hold their values, and tx_en_o and rx_en_o are 0. Only reset clears bus-off.
- R8: lec_o takes err_code_i on a transmit or receive error event. The codes are 0 none, 1 stuff, 2 form, 3 acknowledge, 4 bit1, 5 bit0, 6 CRC. Code 7 leaves lec_o unchanged, and lec_o never changes without an error event.
- R9: suspend_o is 1 for exactly the cycle after a tx_err_i or tx_ok_i strobe that arrives while passive_o is 1.
- R10: After a synchronous active-low reset:
  - tec_o, rec_o and lec_o are 0;
  - warn_o, passive_o, busoff_o, flag_recessive_o and suspend_o are 0;
  - tx_en_o and rx_en_o are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Frame transmitted without error |
| rx_ok_i | input | 1 | Frame received without error |
| err_code_i | input | 3 | Error type for the current error strobe |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 9 | Receive error counter |
| warn_o | output | 1 | Either counter at 96 or more |
| passive_o | output | 1 | Node is error-passive |
| busoff_o | output | 1 | Node is bus-off |
| lec_o | output | 3 | Last error code |
| flag_recessive_o | output | 1 | Error flag polarity: 1 recessive, 0 dominant |
| flag_len_o | output | 3 | Error flag length in bits |
| suspend_o | output | 1 | Extra suspend period before the next transmission |
| tx_en_o | output | 1 | Transmission allowed |
| rx_en_o | output | 1 | Reception allowed |

## Verification
Two events can coincide in one cycle: an error strobe and a success strobe for the same counter. The bench drives tx_err_i with tx_ok_i together, and rx_err_i with rx_ok_i together, from known counter values. It expects exactly +8 on the next cycle. A second coincidence is the transmit error that crosses 255 arriving together with receive traffic. The bench checks that the receive counter still moves in that cycle and then freezes, because bus-off is set by that same strobe.

// File: rtl/can_fc_pkg.sv
// Package: shared constants and the last-error-code encoding of the
// fault confinement unit. Assumes a 3-bit error code from the engine.
package can_fc_pkg;
    localparam int CNT_W       = 9;
    localparam int ERR_STEP    = 8;
    localparam int OK_STEP     = 1;
    localparam int WARN_LVL    = 96;
    localparam int PASSIVE_LVL = 127;
    localparam int BUSOFF_LVL  = 255;
    localparam int FLAG_LEN    = 6;
    localparam int LEC_W       = 3;

    typedef enum logic [LEC_W-1:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_KEEP  = 3'd7
    } lec_e;
endpackage

// File: rtl/fc_err_counter.sv
// Module: one error counter. An error adds ERR_STEP and a success
// subtracts OK_STEP, with a floor of zero; the error wins when both come
// together. IS_TX selects the variant: the transmit variant owns the
// sticky bus-off flag, while the receive variant saturates at its maximum.
// Assumes freeze_i is the registered bus-off state of the node.
module fc_err_counter #(
    parameter int CNT_W      = 9,
    parameter int ERR_STEP   = 8,
    parameter int OK_STEP    = 1,
    parameter int BUSOFF_LVL = 255,
    parameter bit IS_TX      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic             err_i,
    input  logic             ok_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             busoff_o
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] STEP_E  = SUM_W'(ERR_STEP);
    localparam logic [CNT_W-1:0] STEP_OK = CNT_W'(OK_STEP);
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);
    localparam logic [SUM_W-1:0] BO_LIM  = SUM_W'(BUSOFF_LVL);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [SUM_W-1:0] sum;

    assign sum = {1'b0, cnt_q} + STEP_E;

    // Purpose: next counter value, with error priority, floor and saturation.
    always_comb begin
        cnt_nxt = cnt_q;
        if (err_i) begin
            if (!IS_TX && (sum > CNT_MAX)) begin
                cnt_nxt = CNT_MAX[CNT_W-1:0];
            end else begin
                cnt_nxt = sum[CNT_W-1:0];
            end
        end else if (ok_i) begin
            if (cnt_q >= STEP_OK) begin
                cnt_nxt = cnt_q - STEP_OK;
            end else begin
                cnt_nxt = '0;
            end
        end
    end

    // Purpose: counter register, frozen while the node is bus-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!freeze_i) begin
            cnt_q <= cnt_nxt;
        end
    end

    assign cnt_o = cnt_q;

    generate
        if (IS_TX) begin : g_tx
            logic bo_q;
            // Purpose: sticky bus-off, set when an error takes the count past the limit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bo_q <= 1'b0;
                end else if (!freeze_i && err_i && (sum > BO_LIM)) begin
                    bo_q <= 1'b1;
                end
            end
            assign busoff_o = bo_q;
        end else begin : g_rx
            assign busoff_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/fc_last_err.sv
// Module: last-error-code register. It loads the engine's code on an
// error event, keeps its value for the "unchanged" code, and is frozen in
// bus-off. Assumes the code is valid in the cycle of the error strobe.
module fc_last_err
    import can_fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic             evt_i,
    input  logic [LEC_W-1:0] code_i,
    output logic [LEC_W-1:0] lec_o
);
    lec_e lec_q;

    // Purpose: load the error type on an error event unless the code means keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lec_q <= LEC_NONE;
        end else if (!freeze_i && evt_i && (lec_e'(code_i) != LEC_KEEP)) begin
            lec_q <= lec_e'(code_i);
        end
    end

    assign lec_o = lec_q;
endmodule

// File: rtl/fc_conf_state.sv
// Module: fault-confinement state decode. It derives the warning and
// passive levels from both counters, the error flag polarity, the bus
// enables, and the registered one-cycle suspend request after a
// transmission in the passive state. Assumes registered counter inputs.
module fc_conf_state #(
    parameter int CNT_W       = 9,
    parameter int WARN_LVL    = 96,
    parameter int PASSIVE_LVL = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  logic             busoff_i,
    input  logic             tx_done_i,
    output logic             warn_o,
    output logic             passive_o,
    output logic             flag_recessive_o,
    output logic             tx_en_o,
    output logic             rx_en_o,
    output logic             suspend_o
);
    localparam logic [CNT_W-1:0] WARN_L = CNT_W'(WARN_LVL);
    localparam logic [CNT_W-1:0] PASS_L = CNT_W'(PASSIVE_LVL);

    logic susp_q;

    // Purpose: level decode of both counters and the bus-off state.
    always_comb begin
        warn_o           = (tec_i >= WARN_L) || (rec_i >= WARN_L);
        passive_o        = !busoff_i && ((tec_i > PASS_L) || (rec_i > PASS_L));
        flag_recessive_o = passive_o || busoff_i;
        tx_en_o          = !busoff_i;
        rx_en_o          = !busoff_i;
    end

    // Purpose: one-cycle suspend after a transmission ends in the passive state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q <= 1'b0;
        end else begin
            susp_q <= tx_done_i && passive_o;
        end
    end

    assign suspend_o = susp_q;
endmodule

// File: rtl/can_fault_conf.sv
// Module: top of the CAN fault confinement unit. It holds the transmit
// and receive error counters, the last error code and the state decode.
// Assumes single-cycle strobes from a protocol engine on the same clock.
module can_fault_conf
    import can_fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic [LEC_W-1:0] err_code_i,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic             warn_o,
    output logic             passive_o,
    output logic             busoff_o,
    output logic [LEC_W-1:0] lec_o,
    output logic             flag_recessive_o,
    output logic [2:0]       flag_len_o,
    output logic             suspend_o,
    output logic             tx_en_o,
    output logic             rx_en_o
);
    logic bo_tx;
    logic bo_rx_unused;

    fc_err_counter #(
        .CNT_W(CNT_W), .ERR_STEP(ERR_STEP), .OK_STEP(OK_STEP),
        .BUSOFF_LVL(BUSOFF_LVL), .IS_TX(1'b1)
    ) i_tec (
        .clk(clk), .rst_n(rst_n), .freeze_i(bo_tx),
        .err_i(tx_err_i), .ok_i(tx_ok_i),
        .cnt_o(tec_o), .busoff_o(bo_tx)
    );

    fc_err_counter #(
        .CNT_W(CNT_W), .ERR_STEP(ERR_STEP), .OK_STEP(OK_STEP),
        .BUSOFF_LVL(BUSOFF_LVL), .IS_TX(1'b0)
    ) i_rec (
        .clk(clk), .rst_n(rst_n), .freeze_i(bo_tx),
        .err_i(rx_err_i), .ok_i(rx_ok_i),
        .cnt_o(rec_o), .busoff_o(bo_rx_unused)
    );

    fc_last_err i_lec (
        .clk(clk), .rst_n(rst_n), .freeze_i(bo_tx),
        .evt_i(tx_err_i || rx_err_i), .code_i(err_code_i),
        .lec_o(lec_o)
    );

    fc_conf_state #(
        .CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASSIVE_LVL(PASSIVE_LVL)
    ) i_state (
        .clk(clk), .rst_n(rst_n), .tec_i(tec_o), .rec_i(rec_o),
        .busoff_i(bo_tx), .tx_done_i(tx_err_i || tx_ok_i),
        .warn_o(warn_o), .passive_o(passive_o),
        .flag_recessive_o(flag_recessive_o),
        .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .suspend_o(suspend_o)
    );

    assign busoff_o   = bo_tx;
    assign flag_len_o = 3'(FLAG_LEN);
endmodule

// File: rtl/can_fault_conf_chk.sv
// Module: assertion checker for the fault confinement unit, bound to the
// top module. It observes ports only.
module can_fault_conf_chk
    import can_fc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tx_err_i,
    input logic             rx_err_i,
    input logic             tx_ok_i,
    input logic             rx_ok_i,
    input logic [LEC_W-1:0] err_code_i,
    input logic [CNT_W-1:0] tec_o,
    input logic [CNT_W-1:0] rec_o,
    input logic             warn_o,
    input logic             passive_o,
    input logic             busoff_o,
    input logic [LEC_W-1:0] lec_o,
    input logic             flag_recessive_o,
    input logic [2:0]       flag_len_o,
    input logic             suspend_o,
    input logic             tx_en_o,
    input logic             rx_en_o
);
    assert_tec_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_i && !busoff_o) |=> (tec_o == $past(tec_o) + 9'd8));

    assert_tec_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ok_i && !tx_err_i && !busoff_o && tec_o != 0) |=> (tec_o == $past(tec_o) - 9'd1));

    assert_rec_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ok_i && !rx_err_i && rec_o == 0) |=> (rec_o == 0));

    assert_rec_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_i && rx_ok_i && !busoff_o && rec_o < 9'd500) |=> (rec_o == $past(rec_o) + 9'd8));

    assert_passive_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        passive_o |-> flag_recessive_o);

    assert_rec_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err_i && !busoff_o && rec_o > 9'd503) |=> (rec_o == 9'd511));

    assert_busoff_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busoff_o) |-> $past(tx_err_i));

    assert_busoff_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_o |=> (busoff_o && $stable(tec_o) && $stable(rec_o) && $stable(lec_o)));

    assert_busoff_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_o |-> (!tx_en_o && !rx_en_o && !passive_o));

    assert_lec_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_err_i || rx_err_i) && !busoff_o && err_code_i != 3'd7) |=> (lec_o == $past(err_code_i)));

    assert_lec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_err_i && !rx_err_i) |=> $stable(lec_o));

    assert_suspend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_err_i || tx_ok_i) && passive_o) |=> suspend_o);
endmodule

bind can_fault_conf can_fault_conf_chk i_chk (.*);

// File: tb/test_can_fault_conf.sv
// Bench: directed scenarios for the fault confinement unit, one task each.
module test_can_fault_conf;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_err_i = 1'b0, rx_err_i = 1'b0, tx_ok_i = 1'b0, rx_ok_i = 1'b0;
    logic [2:0] err_code_i = 3'd0;
    logic [8:0] tec_o, rec_o;
    logic       warn_o, passive_o, busoff_o, flag_recessive_o, suspend_o, tx_en_o, rx_en_o;
    logic [2:0] lec_o, flag_len_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    can_fault_conf i_can_fault_conf (
        .clk(clk), .rst_n(rst_n), .tx_err_i(tx_err_i), .rx_err_i(rx_err_i),
        .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i), .err_code_i(err_code_i),
        .tec_o(tec_o), .rec_o(rec_o), .warn_o(warn_o), .passive_o(passive_o),
        .busoff_o(busoff_o), .lec_o(lec_o), .flag_recessive_o(flag_recessive_o),
        .flag_len_o(flag_len_o), .suspend_o(suspend_o), .tx_en_o(tx_en_o),
        .rx_en_o(rx_en_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle of strobes: drive after a falling edge, sample at the next.
    task automatic step(input bit te, input bit re, input bit to, input bit ro, input logic [2:0] code);
        tx_err_i = te; rx_err_i = re; tx_ok_i = to; rx_ok_i = ro; err_code_i = code;
        @(negedge clk);
        tx_err_i = 1'b0; rx_err_i = 1'b0; tx_ok_i = 1'b0; rx_ok_i = 1'b0; err_code_i = 3'd0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 tec", tec_o, 0);         chk("R10 rec", rec_o, 0);
        chk("R10 lec", lec_o, 0);         chk("R10 warn", warn_o, 0);
        chk("R10 passive", passive_o, 0); chk("R10 busoff", busoff_o, 0);
        chk("R10 flag_rec", flag_recessive_o, 0); chk("R10 suspend", suspend_o, 0);
        chk("R10 tx_en", tx_en_o, 1);     chk("R10 rx_en", rx_en_o, 1);
        chk("R5 flag_len", flag_len_o, 6);
    endtask

    task automatic t_step_and_floor();
        do_reset();
        step(1, 0, 0, 0, 3'd4);  chk("R1 tec +8", tec_o, 8);   chk("R8 lec bit1", lec_o, 4);
        step(0, 1, 0, 0, 3'd2);  chk("R1 rec +8", rec_o, 8);   chk("R8 lec form", lec_o, 2);
        step(1, 0, 0, 0, 3'd7);  chk("R8 keep code", lec_o, 2);
        step(0, 0, 1, 1, 3'd5);  chk("R2 tec -1", tec_o, 15);  chk("R2 rec -1", rec_o, 7);
        chk("R8 no change on ok", lec_o, 2);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 3'd0);
        chk("R2 rec floor", rec_o, 0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        step(1, 0, 1, 0, 3'd1);  chk("R3 tec err+ok", tec_o, 8);
        step(0, 1, 0, 1, 3'd6);  chk("R3 rec err+ok", rec_o, 8);
        step(1, 1, 1, 1, 3'd3);  chk("R3 tec both", tec_o, 16); chk("R3 rec both", rec_o, 16);
    endtask

    task automatic t_warn_passive();
        do_reset();
        for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 3'd1);
        chk("R4 rec 96", rec_o, 96);  chk("R4 warn set", warn_o, 1);
        step(0, 0, 0, 1, 3'd0);
        chk("R4 warn clear", warn_o, 0);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 3'd1);
        chk("R5 rec 127", rec_o, 127); chk("R5 not passive", passive_o, 0);
        chk("R5 dominant flag", flag_recessive_o, 0);
        step(0, 1, 0, 0, 3'd1);
        chk("R5 passive", passive_o, 1); chk("R5 recessive flag", flag_recessive_o, 1);
        step(0, 0, 1, 0, 3'd0);
        chk("R9 suspend after tx", suspend_o, 1);
        @(negedge clk);
        chk("R9 suspend one cycle", suspend_o, 0);
        step(0, 0, 0, 1, 3'd0);
        chk("R9 no suspend on rx", suspend_o, 0);
    endtask

    task automatic t_rec_sat();
        do_reset();
        for (int i = 0; i < 70; i++) step(0, 1, 0, 0, 3'd6);
        chk("R6 rec saturates", rec_o, 511);
        chk("R6 no busoff from rec", busoff_o, 0);
        chk("R6 passive from rec", passive_o, 1);
    endtask

    task automatic t_busoff();
        do_reset();
        for (int i = 0; i < 31; i++) step(1, 0, 0, 0, 3'd4);
        chk("R6 tec 248", tec_o, 248); chk("R6 not yet busoff", busoff_o, 0);
        step(1, 1, 0, 0, 3'd5);
        chk("R6 busoff", busoff_o, 1);  chk("R6 tec 256", tec_o, 256);
        chk("R6 rec moved", rec_o, 8);
        chk("R7 tx_en off", tx_en_o, 0); chk("R7 rx_en off", rx_en_o, 0);
        chk("R5 busoff recessive", flag_recessive_o, 1); chk("R5 passive off", passive_o, 0);
        step(0, 1, 1, 0, 3'd3);
        chk("R7 tec frozen", tec_o, 256); chk("R7 rec frozen", rec_o, 8);
        chk("R7 lec frozen", lec_o, 5);
        for (int i = 0; i < 300; i++) step(0, 0, 1, 1, 3'd0);
        chk("R7 traffic keeps busoff", busoff_o, 1);
        do_reset();
        chk("R7 reset clears busoff", busoff_o, 0); chk("R7 reset tec", tec_o, 0);
        chk("R7 tx_en back", tx_en_o, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_step_and_floor();
        t_same_cycle();
        t_warn_passive();
        t_rec_sat();
        t_busoff();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule